// File: doc/BRIEF.md
# Functional Unit Pool Allocator

This block manages a fixed pool of execution units on behalf of an issue stage. Each unit is set up with the set of operation classes it can execute. Each cycle the issue stage may present one request that names an operation class. In the same cycle the allocator returns one of three answers: a granted unit index, a code meaning no unit in the pool supports the class, or a code meaning every unit that supports it is busy. A granted unit becomes busy on the next clock edge. The allocator never frees a unit by itself. The issue stage returns units through a release port, and a release only takes effect at the end of the cycle in which it is presented.

Each class keeps its own rotating search start. A search walks the capable units in ascending index order and wraps around. It begins just after the unit most recently granted for that class, so recently used units move to the back of the order. Unit capabilities, per-class maximum latency and per-class pipelined flags are captured from configuration inputs while reset is held. The latency and pipelined flag of the class on the request input are always shown on lookup outputs. A drained output reports that no unit is busy.

Top module: `fu_pool_alloc`

## Requirements
- R1: While reset is held and in the first cycle after it, every unit is free. With `req_valid` low, `rsp_code` is 2'b00 (idle).
- R2: A valid request for a class that no unit supports returns `rsp_code` 2'b11 (no capable unit), whatever the busy state of the units.
- R3: A valid request for a supported class with at least one free capable unit returns `rsp_code` 2'b01 (grant) in the same cycle, with `rsp_unit` set to a free unit that supports the class. That unit is busy from the next cycle on.
- R4: For each class, the search starts at the unit index that follows the last unit granted for that class, with a start of 0 after reset. It proceeds in ascending order with wrap-around and grants the first unit that is both capable and free.
- R5: If every unit that supports the requested class is busy, `rsp_code` is 2'b10 (no free unit), no unit changes state, and the search start of that class is unchanged.
- R6: A release (`rel_valid`, `rel_unit`) takes effect only at the clock edge that ends the cycle. A request in the same cycle still sees the released unit as busy.
- R7: If a unit is granted and released in the same cycle, the grant wins and the unit is busy afterwards.
- R8: `drained` is 1 exactly when no unit is busy.
- R9: `class_latency` and `class_pipelined` show the configured latency and pipelined flag of the class on `req_class`, whether or not `req_valid` is high.
- R10: Configuration inputs are captured only while `rst` is high. Changes to them after reset have no effect on lookups or grants. Unit u's capability mask is `cfg_caps[u*NUM_CLASSES +: NUM_CLASSES]`, with bit c for class c. The latency of class c is `cfg_lat[c*LAT_W +: LAT_W]`, and its pipelined flag is `cfg_pipe[c]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; configuration is captured while high |
| cfg_caps | input | NUM_UNITS*NUM_CLASSES | Per-unit capability masks |
| cfg_lat | input | NUM_CLASSES*LAT_W | Per-class maximum operation latency |
| cfg_pipe | input | NUM_CLASSES | Per-class pipelined flag |
| req_valid | input | 1 | Allocation request present |
| req_class | input | $clog2(NUM_CLASSES) | Requested operation class, also the lookup index |
| rsp_code | output | 2 | 00 idle, 01 grant, 10 no free unit, 11 no capable unit |
| rsp_unit | output | $clog2(NUM_UNITS) | Granted unit index, 0 when there is no grant |
| class_latency | output | LAT_W | Latency of class `req_class` |
| class_pipelined | output | 1 | Pipelined flag of class `req_class` |
| rel_valid | input | 1 | Release request present |
| rel_unit | input | $clog2(NUM_UNITS) | Unit to release at the end of the cycle |
| drained | output | 1 | No unit is busy |

## Verification
The allocation search and the deferred release can act in the same cycle, and the tests provoke that collision in two ways. In the first, the bench releases the last free-able unit of a class while it requests that class. The response must be "no free unit", and a repeat of the request one cycle later must grant exactly that unit. In the second, the bench releases an idle unit in the same cycle in which it is granted. A follow-up request must find the unit still busy, because the grant has priority.

// File: rtl/fupa_pkg.sv
package fupa_pkg;

    typedef enum logic [1:0] {
        RSP_IDLE   = 2'b00,
        RSP_GRANT  = 2'b01,
        RSP_NOFREE = 2'b10,
        RSP_NOCAP  = 2'b11
    } rsp_e;

    typedef struct packed {
        logic valid;
        logic last;
    } find_t;

endpackage

// File: rtl/fupa_cfg_store.sv
module fupa_cfg_store #(
    parameter int NUM_UNITS   = 8,
    parameter int NUM_CLASSES = 8,
    parameter int LAT_W       = 6
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [NUM_UNITS*NUM_CLASSES-1:0]   cfg_caps,
    input  logic [NUM_CLASSES*LAT_W-1:0]       cfg_lat,
    input  logic [NUM_CLASSES-1:0]             cfg_pipe,
    output logic [NUM_CLASSES-1:0][NUM_UNITS-1:0] cls_units,
    output logic [NUM_CLASSES-1:0]             cls_cap,
    output logic [NUM_CLASSES-1:0][LAT_W-1:0]  cls_lat,
    output logic [NUM_CLASSES-1:0]             cls_pipe
);
    logic [NUM_UNITS*NUM_CLASSES-1:0] caps_q;
    logic [NUM_CLASSES*LAT_W-1:0]     lat_q;
    logic [NUM_CLASSES-1:0]           pipe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            caps_q <= cfg_caps;
            lat_q  <= cfg_lat;
            pipe_q <= cfg_pipe;
        end
    end

    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
        for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
            assign cls_units[c][u] = caps_q[u*NUM_CLASSES + c];
        end
        assign cls_cap[c]  = |cls_units[c];
        assign cls_lat[c]  = lat_q[c*LAT_W +: LAT_W];
        assign cls_pipe[c] = pipe_q[c];
    end

endmodule

// File: rtl/fupa_pick.sv
module fupa_pick #(
    parameter int NUM_UNITS = 8,
    localparam int IW = $clog2(NUM_UNITS)
) (
    input  logic [NUM_UNITS-1:0] cand,
    input  logic [IW-1:0]        start,
    output logic                 found,
    output logic [IW-1:0]        idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < NUM_UNITS; k++) begin
            int p;
            p = (int'(start) + k) % NUM_UNITS;
            if (!found && cand[p]) begin
                found = 1'b1;
                idx   = p[IW-1:0];
            end
        end
    end

endmodule

// File: rtl/fupa_busy.sv
module fupa_busy #(
    parameter int NUM_UNITS = 8,
    localparam int IW = $clog2(NUM_UNITS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 grant_v,
    input  logic [IW-1:0]        grant_idx,
    input  logic                 rel_v,
    input  logic [IW-1:0]        rel_idx,
    output logic [NUM_UNITS-1:0] busy,
    output logic                 drained
);
    logic [NUM_UNITS-1:0] busy_q;
    logic [NUM_UNITS-1:0] set_mask;
    logic [NUM_UNITS-1:0] clr_mask;

    always_comb begin
        set_mask = '0;
        clr_mask = '0;
        if (grant_v) set_mask[grant_idx] = 1'b1;
        if (rel_v)   clr_mask[rel_idx]   = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) busy_q <= '0;
        else     busy_q <= (busy_q & ~clr_mask) | set_mask;
    end

    assign busy    = busy_q;
    assign drained = (busy_q == '0);

    // R3
    grant_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
        grant_v |=> busy_q[$past(grant_idx)]);

    // R3
    no_busy_grant_chk: assert property (@(posedge clk) disable iff (rst)
        grant_v |-> !busy_q[grant_idx]);

    // R6
    release_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (rel_v && !(grant_v && grant_idx == rel_idx)) |=> !busy_q[$past(rel_idx)]);

    // R7
    grant_beats_release_chk: assert property (@(posedge clk) disable iff (rst)
        (grant_v && rel_v && grant_idx == rel_idx) |=> busy_q[$past(rel_idx)]);

endmodule

// File: rtl/fu_pool_alloc.sv
module fu_pool_alloc #(
    parameter int NUM_UNITS   = 8,
    parameter int NUM_CLASSES = 8,
    parameter int LAT_W       = 6,
    localparam int IW = $clog2(NUM_UNITS),
    localparam int CW = $clog2(NUM_CLASSES)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NUM_UNITS*NUM_CLASSES-1:0] cfg_caps,
    input  logic [NUM_CLASSES*LAT_W-1:0]     cfg_lat,
    input  logic [NUM_CLASSES-1:0]           cfg_pipe,
    input  logic                             req_valid,
    input  logic [CW-1:0]                    req_class,
    output logic [1:0]                       rsp_code,
    output logic [IW-1:0]                    rsp_unit,
    output logic [LAT_W-1:0]                 class_latency,
    output logic                             class_pipelined,
    input  logic                             rel_valid,
    input  logic [IW-1:0]                    rel_unit,
    output logic                             drained
);
    import fupa_pkg::*;

    logic [NUM_CLASSES-1:0][NUM_UNITS-1:0] cls_units;
    logic [NUM_CLASSES-1:0]                cls_cap;
    logic [NUM_CLASSES-1:0][LAT_W-1:0]     cls_lat;
    logic [NUM_CLASSES-1:0]                cls_pipe;
    logic [NUM_UNITS-1:0]                  busy;
    logic [NUM_UNITS-1:0]                  cand;
    logic [IW-1:0]                         start_q [NUM_CLASSES];
    logic [IW-1:0]                         pick_idx;
    logic [IW-1:0]                         next_start;
    logic                                  pick_found;
    logic                                  grant_v;
    rsp_e                                  rsp;

    fupa_cfg_store #(
        .NUM_UNITS(NUM_UNITS), .NUM_CLASSES(NUM_CLASSES), .LAT_W(LAT_W)
    ) i_cfg (
        .clk(clk), .rst(rst),
        .cfg_caps(cfg_caps), .cfg_lat(cfg_lat), .cfg_pipe(cfg_pipe),
        .cls_units(cls_units), .cls_cap(cls_cap),
        .cls_lat(cls_lat), .cls_pipe(cls_pipe)
    );

    assign cand = cls_units[req_class] & ~busy;

    fupa_pick #(.NUM_UNITS(NUM_UNITS)) i_pick (
        .cand(cand), .start(start_q[req_class]),
        .found(pick_found), .idx(pick_idx)
    );

    always_comb begin
        if (!req_valid)              rsp = RSP_IDLE;
        else if (!cls_cap[req_class]) rsp = RSP_NOCAP;
        else if (pick_found)         rsp = RSP_GRANT;
        else                         rsp = RSP_NOFREE;
    end

    assign grant_v    = (rsp == RSP_GRANT);
    assign rsp_code   = rsp;
    assign rsp_unit   = grant_v ? pick_idx : '0;
    assign next_start = (int'(pick_idx) == NUM_UNITS - 1) ? '0 : pick_idx + 1'b1;

    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_start
        always_ff @(posedge clk) begin
            if (rst)
                start_q[c] <= '0;
            else if (grant_v && int'(req_class) == c)
                start_q[c] <= next_start;
        end
    end

    fupa_busy #(.NUM_UNITS(NUM_UNITS)) i_busy (
        .clk(clk), .rst(rst),
        .grant_v(grant_v), .grant_idx(pick_idx),
        .rel_v(rel_valid), .rel_idx(rel_unit),
        .busy(busy), .drained(drained)
    );

    assign class_latency   = cls_lat[req_class];
    assign class_pipelined = cls_pipe[req_class];

    // R2
    nocap_only_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp == RSP_NOCAP) |-> (cls_units[req_class] == '0));

    // R3
    grant_capable_chk: assert property (@(posedge clk) disable iff (rst)
        grant_v |-> cls_units[req_class][rsp_unit]);

    // R8
    drained_grants_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && drained && cls_cap[req_class]) |-> grant_v);

    // R5
    nofree_all_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp == RSP_NOFREE) |-> ((cls_units[req_class] & ~busy) == '0));

endmodule

// File: tb/test_fu_pool_alloc.sv
module test_fu_pool_alloc;
    localparam int N  = 8;
    localparam int C  = 8;
    localparam int LW = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N*C-1:0]  cfg_caps;
    logic [C*LW-1:0] cfg_lat;
    logic [C-1:0]    cfg_pipe;
    logic            req_valid = 1'b0;
    logic [2:0]      req_class = '0;
    logic [1:0]      rsp_code;
    logic [2:0]      rsp_unit;
    logic [LW-1:0]   class_latency;
    logic            class_pipelined;
    logic            rel_valid = 1'b0;
    logic [2:0]      rel_unit = '0;
    logic            drained;

    int tests = 0;
    int fails = 0;

    localparam logic [1:0] IDLE = 2'b00, GRANT = 2'b01, NOFREE = 2'b10, NOCAP = 2'b11;

    always #10 clk = ~clk;

    fu_pool_alloc #(.NUM_UNITS(N), .NUM_CLASSES(C), .LAT_W(LW)) i_fu_pool_alloc (
        .clk(clk), .rst(rst), .cfg_caps(cfg_caps), .cfg_lat(cfg_lat), .cfg_pipe(cfg_pipe),
        .req_valid(req_valid), .req_class(req_class), .rsp_code(rsp_code),
        .rsp_unit(rsp_unit), .class_latency(class_latency),
        .class_pipelined(class_pipelined), .rel_valid(rel_valid),
        .rel_unit(rel_unit), .drained(drained)
    );

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // one cycle: drive at negedge, settle, leave results for caller to check
    task automatic step(input logic v, input int cls, input logic rv, input int ru);
        @(negedge clk);
        req_valid = v;
        req_class = cls[2:0];
        rel_valid = rv;
        rel_unit  = ru[2:0];
        #2;
    endtask

    task automatic expect_grant(input string tag, input int cls, input int unit);
        step(1'b1, cls, 1'b0, 0);
        chk({tag, " code"}, rsp_code, GRANT);
        chk({tag, " unit"}, rsp_unit, unit);
    endtask

    task automatic release_unit(input int u);
        step(1'b0, 0, 1'b1, u);
    endtask

    task automatic t_reset;
        step(1'b0, 0, 1'b0, 0);
        chk("R1 idle code", rsp_code, IDLE);
        chk("R1 drained after reset", drained, 1);
    endtask

    task automatic t_lookup;
        step(1'b0, 3, 1'b0, 0);
        chk("R9 latency class3", class_latency, 7);
        chk("R9 pipe class3", class_pipelined, 1);
        step(1'b0, 2, 1'b0, 0);
        chk("R9 latency class2", class_latency, 5);
        chk("R9 pipe class2", class_pipelined, 0);
        chk("R10 latency after cfg change", class_latency, 5);
    endtask

    task automatic t_nocap;
        step(1'b1, 6, 1'b0, 0);
        chk("R2 unsupported class", rsp_code, NOCAP);
        step(1'b1, 7, 1'b0, 0);
        chk("R2 unsupported class7", rsp_code, NOCAP);
    endtask

    task automatic t_fill;
        expect_grant("R3 first grant", 0, 0);
        step(1'b0, 0, 1'b0, 0);
        chk("R8 not drained", drained, 0);
        expect_grant("R4 next", 0, 1);
        expect_grant("R4 next", 0, 2);
        expect_grant("R4 next", 0, 3);
        step(1'b1, 0, 1'b0, 0);
        chk("R5 class0 all busy", rsp_code, NOFREE);
        step(1'b1, 4, 1'b0, 0);
        chk("R5 class4 unit busy", rsp_code, NOFREE);
        step(1'b1, 4, 1'b0, 0);
        chk("R2 busy is not nocap", rsp_code, NOFREE);
    endtask

    task automatic t_deferred;
        step(1'b1, 0, 1'b1, 2);
        chk("R6 same-cycle release not visible", rsp_code, NOFREE);
        expect_grant("R6 released unit next cycle", 0, 2);
    endtask

    task automatic t_rotate;
        release_unit(3);
        release_unit(1);
        expect_grant("R4 start after last grant", 0, 3);
        expect_grant("R4 wrap around", 0, 1);
    endtask

    task automatic t_collide;
        step(1'b1, 2, 1'b1, 6);
        chk("R7 grant code", rsp_code, GRANT);
        chk("R7 grant unit", rsp_unit, 6);
        step(1'b1, 2, 1'b0, 0);
        chk("R7 unit stays busy", rsp_code, NOFREE);
        release_unit(6);
        expect_grant("R7 regrant after release", 2, 6);
        release_unit(6);
    endtask

    task automatic t_drain;
        release_unit(0);
        release_unit(1);
        release_unit(2);
        chk("R8 one unit still busy", drained, 0);
        release_unit(3);
        chk("R8 release deferred", drained, 0);
        step(1'b0, 0, 1'b0, 0);
        chk("R8 drained after last release", drained, 1);
        expect_grant("R4 class3 start 0", 3, 1);
        expect_grant("R4 class3 next", 3, 7);
    endtask

    initial begin
        // unit masks: bit c = class c
        cfg_caps = {8'h08, 8'h04, 8'h02, 8'h02, 8'h01, 8'h01, 8'h09, 8'h11};
        for (int c = 0; c < C; c++) begin
            cfg_lat[c*LW +: LW] = LW'(2*c + 1);
            cfg_pipe[c] = c[0];
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cfg_lat  = '1;
        cfg_pipe = '0;
        cfg_caps = '1;
        t_reset();
        t_lookup();
        t_nocap();
        t_fill();
        t_deferred();
        t_rotate();
        t_collide();
        t_drain();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule